// File: doc/BRIEF.md
# Descriptor Ring Pointer Unit

This block keeps the descriptor addresses for one DMA channel whose descriptors are laid out as a ring in memory. Software sets up three address registers: the ring base, the pointer to the next descriptor to fetch, and the pointer to the most recently finished descriptor. The channel must be disabled while it does so. After that, the DMA engine signals each finished descriptor with a one-cycle completion pulse and that descriptor's end-of-list flag. The block then moves the pointers forward.

The ring has no address or count limit. A finished descriptor with its end-of-list flag clear makes the pointer step forward by the descriptor size. The size is chosen at run time from a 2-bit length code that the transmit and receive instances share. A finished descriptor with the flag set sends the pointer back to the ring base. One cycle after each accepted completion, a strobe tells the fetch engine that the next address is ready. A transmit ring must hold at least five frames. A receive ring has no minimum, so one received frame may use every descriptor in the ring. The block stores no count, so it neither enforces nor relies on either rule.

Top module: `desc_ring_ptr`

## Requirements
- R1: A synchronous active-high reset sets the base, next and finished pointers, the end-of-list status bit and the next-address strobe to zero.
- R2: While `chan_en` is 0, a write with `wr_en`=1 loads `wr_data` into one register chosen by `wr_sel`: 0 = base, 1 = next pointer, 2 = finished pointer. Code 3 changes nothing. The stored value has its low address bits cleared to match the current descriptor size: 4 bits for 16 bytes, 5 bits for 32 bytes, 6 bits for 64 bytes.
- R3: While `chan_en` is 1, software writes have no effect on any pointer.
- R4: An accepted completion with end-of-list 0 sets the next pointer to its old value plus the descriptor size. The finished pointer takes the old next-pointer value.
- R5: An accepted completion with end-of-list 1 loads the next pointer from the base register. The finished pointer takes the old next-pointer value.
- R6: After each accepted completion, the status bit `eol_seen` equals that completion's end-of-list flag.
- R7: The length code `len_sel` selects the descriptor size: 00 = 16 bytes, 01 = 32 bytes, 10 = 64 bytes, 11 (reserved) = 16 bytes.
- R8: `next_valid` is high for exactly the one cycle after each accepted completion, and low at all other times.
- R9: While enabled, a completion and a write in the same cycle apply the completion and discard the write.
- R10: A completion pulse while `chan_en` is 0 is ignored: the pointers, the status bit and `next_valid` do not change.
- R11: Advancing past the top of the 32-bit address space wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_en | input | 1 | Channel enable; writes blocked while 1, completions accepted only while 1 |
| len_sel | input | 2 | Descriptor length code, shared between channels |
| wr_en | input | 1 | Software register write strobe |
| wr_sel | input | 2 | Write target: 0 base, 1 next pointer, 2 finished pointer, 3 none |
| wr_data | input | 32 | Write data (an address) |
| done | input | 1 | One-cycle descriptor completion pulse |
| done_eol | input | 1 | End-of-list flag of the finished descriptor |
| base_ptr | output | 32 | Ring base address |
| next_ptr | output | 32 | Address of the next descriptor to process |
| fin_ptr | output | 32 | Address of the last finished descriptor |
| eol_seen | output | 1 | End-of-list flag of the last finished descriptor |
| next_valid | output | 1 | One-cycle strobe: next pointer has just been updated |

## Verification
The hardest case to reach from the ports is a completion and a software write arriving in the same cycle while the channel is enabled. The pointers only move while enabled, and the write gate only opens while disabled, so this collision needs deliberate stimulus. The bench first loads a known ring while disabled. It then enables the channel and raises `done` and `wr_en` on the same edge, with the write aimed at the next pointer. The test passes only if the pointer shows the stride step and not the written value. A second test places the next pointer one stride below 2^32 to force the wrap-around.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
  localparam int ADDR_W  = 32;
  localparam int LEN_W   = 2;
  localparam int SEL_W   = 2;

  // software write targets
  typedef enum logic [SEL_W-1:0] {
    WR_BASE = 2'd0,
    WR_NEXT = 2'd1,
    WR_FIN  = 2'd2,
    WR_NONE = 2'd3
  } wr_tgt_e;

  // log2 of the descriptor size for each length code; reserved code -> smallest
  function automatic int unsigned len_shift(input logic [LEN_W-1:0] code);
    case (code)
      2'b01:   len_shift = 5;
      2'b10:   len_shift = 6;
      default: len_shift = 4;
    endcase
  endfunction
endpackage

// File: rtl/ring_stride_dec.sv
module ring_stride_dec
  import ring_ptr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LEN_W
) (
  input  logic [LW-1:0] len_sel,
  output logic [AW-1:0] stride,
  output logic [AW-1:0] low_mask
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  always_comb begin
    stride   = ONE << len_shift(len_sel);
    low_mask = stride - ONE;
  end
endmodule

// File: rtl/ring_next_calc.sv
module ring_next_calc
  import ring_ptr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] cur_ptr,
  input  logic [AW-1:0] base_ptr,
  input  logic [AW-1:0] stride,
  input  logic          eol,
  output logic [AW-1:0] next_addr
);
  logic [AW-1:0] stepped;

  always_comb begin
    stepped   = cur_ptr + stride;  // wraps modulo 2^AW
    next_addr = eol ? base_ptr : stepped;
  end
endmodule

// File: rtl/ring_ptr_bank.sv
module ring_ptr_bank
  import ring_ptr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chan_en,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic          done,
  input  logic          done_eol,
  input  logic [AW-1:0] next_addr,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] next_q,
  output logic [AW-1:0] fin_q,
  output logic          eol_q,
  output logic          nv_q
);
  logic take_done;
  logic take_wr;

  always_comb begin
    take_done = done && chan_en;
    take_wr   = wr_en && !chan_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      next_q <= '0;
      fin_q  <= '0;
      eol_q  <= 1'b0;
      nv_q   <= 1'b0;
    end else begin
      nv_q <= take_done;
      if (take_done) begin
        next_q <= next_addr;
        fin_q  <= next_q;
        eol_q  <= done_eol;
      end else if (take_wr) begin
        case (wr_sel)
          WR_BASE: base_q <= wr_addr;
          WR_NEXT: next_q <= wr_addr;
          WR_FIN:  fin_q  <= wr_addr;
          default: ;
        endcase
      end
    end
  end

  // R4
  fin_track_chk: assert property (@(posedge clk) disable iff (rst)
    (done && chan_en) |=> (fin_q == $past(next_q)));
  // R5
  eol_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (done && chan_en && done_eol) |=> (next_q == $past(base_q)));
  // R6
  eol_status_chk: assert property (@(posedge clk) disable iff (rst)
    (done && chan_en) |=> (eol_q == $past(done_eol)));
  // R8
  nv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    nv_q |-> $past(done && chan_en));
  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_en && !done) |=> ($stable(next_q) && $stable(base_q) && $stable(fin_q)));
  // R10
  dis_done_chk: assert property (@(posedge clk) disable iff (rst)
    (!chan_en && !wr_en) |=> ($stable(next_q) && $stable(eol_q) && !nv_q));
endmodule

// File: rtl/desc_ring_ptr.sv
module desc_ring_ptr
  import ring_ptr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LEN_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chan_en,
  input  logic [LW-1:0] len_sel,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          done,
  input  logic          done_eol,
  output logic [AW-1:0] base_ptr,
  output logic [AW-1:0] next_ptr,
  output logic [AW-1:0] fin_ptr,
  output logic          eol_seen,
  output logic          next_valid
);
  logic [AW-1:0] stride;
  logic [AW-1:0] low_mask;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] next_addr;

  ring_stride_dec #(.AW(AW), .LW(LW)) u_dec (
    .len_sel  (len_sel),
    .stride   (stride),
    .low_mask (low_mask)
  );

  always_comb wr_addr = wr_data & ~low_mask;

  ring_next_calc #(.AW(AW)) u_calc (
    .cur_ptr   (next_ptr),
    .base_ptr  (base_ptr),
    .stride    (stride),
    .eol       (done_eol),
    .next_addr (next_addr)
  );

  ring_ptr_bank #(.AW(AW), .SW(SW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .chan_en   (chan_en),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_addr   (wr_addr),
    .done      (done),
    .done_eol  (done_eol),
    .next_addr (next_addr),
    .base_q    (base_ptr),
    .next_q    (next_ptr),
    .fin_q     (fin_ptr),
    .eol_q     (eol_seen),
    .nv_q      (next_valid)
  );
endmodule

// File: tb/tb_desc_ring_ptr.sv
module tb_desc_ring_ptr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chan_en = 1'b0;
  logic [1:0]  len_sel = 2'b00;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        done = 1'b0;
  logic        done_eol = 1'b0;
  logic [31:0] base_ptr, next_ptr, fin_ptr;
  logic        eol_seen, next_valid;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  desc_ring_ptr dut (
    .clk(clk), .rst(rst), .chan_en(chan_en), .len_sel(len_sel),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .done(done), .done_eol(done_eol),
    .base_ptr(base_ptr), .next_ptr(next_ptr), .fin_ptr(fin_ptr),
    .eol_seen(eol_seen), .next_valid(next_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [1:0] sel, input logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one completion pulse; after it, sample at the negedge following the update edge
  task automatic complete(input logic eol);
    done = 1'b1; done_eol = eol;
    @(negedge clk);
    done = 1'b0; done_eol = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 base", base_ptr, 32'h0);
    chk("R1 next", next_ptr, 32'h0);
    chk("R1 fin", fin_ptr, 32'h0);
    chk("R1 eol", {31'b0, eol_seen}, 32'h0);
    chk("R1 nv", {31'b0, next_valid}, 32'h0);
  endtask

  task automatic t_writes();
    chan_en = 1'b0; len_sel = 2'b00;
    sw_write(2'd0, 32'h1000_001F);
    chk("R2 base align16", base_ptr, 32'h1000_0010);
    sw_write(2'd1, 32'h1000_001F);
    chk("R2 next align16", next_ptr, 32'h1000_0010);
    sw_write(2'd2, 32'h1000_00F7);
    chk("R2 fin align16", fin_ptr, 32'h1000_00F0);
    sw_write(2'd3, 32'hAAAA_AAAA);
    chk("R2 sel3 base", base_ptr, 32'h1000_0010);
    chk("R2 sel3 next", next_ptr, 32'h1000_0010);
    chk("R2 sel3 fin", fin_ptr, 32'h1000_00F0);
    len_sel = 2'b10;
    sw_write(2'd0, 32'h2000_007F);
    chk("R2 R7 align64", base_ptr, 32'h2000_0040);
    len_sel = 2'b01;
    sw_write(2'd0, 32'h3000_003F);
    chk("R2 R7 align32", base_ptr, 32'h3000_0020);
  endtask

  task automatic t_advance();
    chan_en = 1'b0; len_sel = 2'b00;
    sw_write(2'd0, 32'h0000_1000);
    sw_write(2'd1, 32'h0000_1000);
    sw_write(2'd2, 32'h0000_1030);
    chan_en = 1'b1;
    complete(1'b0);
    chk("R4 step next", next_ptr, 32'h0000_1010);
    chk("R4 fin", fin_ptr, 32'h0000_1000);
    chk("R6 eol0", {31'b0, eol_seen}, 32'h0);
    chk("R8 nv high", {31'b0, next_valid}, 32'h1);
    @(negedge clk);
    chk("R8 nv single", {31'b0, next_valid}, 32'h0);
    complete(1'b0);
    chk("R4 step2", next_ptr, 32'h0000_1020);
    complete(1'b1);
    chk("R5 reload", next_ptr, 32'h0000_1000);
    chk("R5 fin", fin_ptr, 32'h0000_1020);
    chk("R6 eol1", {31'b0, eol_seen}, 32'h1);
    chk("R8 nv back-to-back", {31'b0, next_valid}, 32'h1);
  endtask

  task automatic t_strides();
    chan_en = 1'b1;
    len_sel = 2'b01; complete(1'b0);
    chk("R7 len32", next_ptr, 32'h0000_1020);
    len_sel = 2'b10; complete(1'b0);
    chk("R7 len64", next_ptr, 32'h0000_1060);
    len_sel = 2'b11; complete(1'b0);
    chk("R7 reserved16", next_ptr, 32'h0000_1070);
    len_sel = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_enabled_write();
    chan_en = 1'b1;
    sw_write(2'd0, 32'hDEAD_0000);
    chk("R3 base kept", base_ptr, 32'h0000_1000);
    sw_write(2'd2, 32'hDEAD_0000);
    chk("R3 fin kept", fin_ptr, 32'h0000_1060);
    // collision: write to next pointer and completion together
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'hBEEF_0000;
    done = 1'b1; done_eol = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; done = 1'b0;
    chk("R9 completion wins", next_ptr, 32'h0000_1080);
    chk("R9 fin", fin_ptr, 32'h0000_1070);
  endtask

  task automatic t_disabled_done();
    chan_en = 1'b0;
    @(negedge clk);
    complete(1'b1);
    chk("R10 next kept", next_ptr, 32'h0000_1080);
    chk("R10 fin kept", fin_ptr, 32'h0000_1070);
    chk("R10 eol kept", {31'b0, eol_seen}, 32'h0);
    chk("R10 no nv", {31'b0, next_valid}, 32'h0);
  endtask

  task automatic t_wrap();
    chan_en = 1'b0; len_sel = 2'b00;
    sw_write(2'd1, 32'hFFFF_FFF0);
    chan_en = 1'b1;
    complete(1'b0);
    chk("R11 wrap", next_ptr, 32'h0000_0000);
    chk("R11 fin", fin_ptr, 32'hFFFF_FFF0);
    chan_en = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_writes();
    t_advance();
    t_strides();
    t_enabled_write();
    t_disabled_done();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule